// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between the load/store stage of a processor and a data memory that is one 32-bit word wide. It forms the effective byte address from a base register value and a 16-bit signed displacement. It then splits each access into a word address and a set of byte-lane enables. On stores it places the source data into the addressed lanes. On loads it picks the addressed bytes out of the word that memory returns and zero-extends them.

Lanes are mapped big-endian: the lowest byte address within a word selects the most significant byte. Every access must be naturally aligned for its size. An access that breaks this rule is flagged and suppressed. Memory is assumed to return read data one cycle after the request. The unit therefore keeps the offset, size and alignment of each load for one cycle and produces the load result in the following cycle.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `base_i` plus `offset_i` sign-extended to 32 bits, wrapping modulo 2^32. `mem_addr_o` is that address with its two least significant bits forced to zero.
- R2: Lane i of a word is bits 8i+7:8i and is enabled by `mem_be_o[i]`. The byte at offset k within the word (effective address bits 1:0) lives in lane 3-k, so offset 0 is bits 31:24.
- R3: Size code 0 (byte) enables exactly one lane, lane 3-k. Size code 1 (halfword) enables lanes 3 and 2 at offset 0, and lanes 1 and 0 at offset 2. Size code 2 (word) enables all four lanes.
- R4: On a store, `mem_wdata_o` holds the low byte of `wdata_i` copied into every lane for a byte store, and the low halfword copied into both halves for a halfword store. For a word store it holds `wdata_i` unchanged.
- R5: `mem_we_o` is high only for an aligned store request (`req_i`=1, `we_i`=1). A load request still drives its lanes on `mem_be_o` but keeps `mem_we_o` low.
- R6: One cycle after a load request, `load_valid_o` is high and `load_data_o` holds the selected byte or halfword from `rdata_i`, zero-extended into bits 31:8 or 31:16, or the whole word for a word load. In any cycle that does not follow a load request, `load_valid_o` is low and `load_data_o` is zero.
- R7: A misaligned request raises `misalign_o`, drives `mem_be_o` to zero and keeps `mem_we_o` low. A request is misaligned if it is a halfword at an odd address, a word at an address that is not a multiple of 4, or uses the reserved size code 3. A misaligned load still gives `load_valid_o` high in the next cycle, with `load_data_o` equal to zero.
- R8: While `req_i` is low, `mem_be_o`, `mem_we_o` and `misalign_o` are all zero.
- R9: While `rst_n` is low and in the first cycle after it, `load_valid_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| wdata_i | input | 32 | Store source register value |
| rdata_i | input | 32 | Memory read word, one cycle after a load request |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 32 | Store data placed in lanes |
| misalign_o | output | 1 | Alignment violation on the current request |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extracted, zero-extended load result |

## Verification
The hardest case to reach is a displacement whose sign decides both which word is addressed and which lane is selected. An example is a negative offset that carries the address back into the previous word and lands on the last byte. Vectors with displacements of -1 and -4 and a wrap past the top of the address space reach these cases directly. Each load vector presents the fixed word 0xAA1513FF on `rdata_i` in the cycle after its request, so every lane and halfword position gives a distinct, predictable value. Misaligned loads are included so that the zero result is observed on the same delayed path as a normal load.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
   import lsu_align_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  offset,
   input  acc_size_e         size,
   output logic [ADDR_W-1:0] word_addr,
   output logic [OFS_W-1:0]  lane_ofs,
   output logic              mis
);
   logic [ADDR_W-1:0] eff;

   // sign-extended displacement added to the base (R1)
   assign eff       = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
   assign word_addr = {eff[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
   assign lane_ofs  = eff[OFS_W-1:0];

   // natural alignment per access size (R7)
   always_comb begin
      case (size)
         SZ_BYTE: mis = 1'b0;
         SZ_HALF: mis = lane_ofs[0];
         SZ_WORD: mis = |lane_ofs;
         default: mis = 1'b1;
      endcase
   end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic              active,
   input  acc_size_e         size,
   input  logic [OFS_W-1:0]  lane_ofs,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] placed
);
   // big-endian: lane i serves byte offset LANES-1-i (R2, R3)
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int K = LANES - 1 - i;
      localparam logic [OFS_W-1:0] K_OFS = OFS_W'(K);
      always_comb begin
         case (size)
            SZ_BYTE: be[i] = active && (lane_ofs == K_OFS);
            SZ_HALF: be[i] = active && (lane_ofs[OFS_W-1:1] == K_OFS[OFS_W-1:1]);
            default: be[i] = active;
         endcase
      end
   end

   // replication puts the source's low bits into whichever lanes are enabled (R4)
   always_comb begin
      case (size)
         SZ_BYTE: placed = {LANES{wdata[7:0]}};
         SZ_HALF: placed = {(LANES/2){wdata[15:0]}};
         default: placed = wdata;
      endcase
   end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  acc_size_e         size,
   input  logic [OFS_W-1:0]  lane_ofs,
   input  logic              mis,
   input  logic [DATA_W-1:0] rdata,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   localparam logic [DATA_W-1:0] MASK_B = DATA_W'(8'hFF);
   localparam logic [DATA_W-1:0] MASK_H = DATA_W'(16'hFFFF);

   logic             vld_q;
   acc_size_e        size_q;
   logic [OFS_W-1:0] ofs_q;
   logic             mis_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         size_q <= SZ_BYTE;
         ofs_q  <= '0;
         mis_q  <= 1'b0;
      end else begin
         vld_q <= capture;
         if (capture) begin
            size_q <= size;
            ofs_q  <= lane_ofs;
            mis_q  <= mis;
         end
      end
   end

   // lane select and zero-extension on the word returned a cycle later (R6)
   always_comb begin
      int sh;
      data = '0;
      if (vld_q && !mis_q) begin
         case (size_q)
            SZ_BYTE: begin
               sh   = 8 * (LANES - 1 - int'(ofs_q));
               data = (rdata >> sh) & MASK_B;
            end
            SZ_HALF: begin
               sh   = 8 * (LANES - 2 - int'(ofs_q));
               data = (rdata >> sh) & MASK_H;
            end
            default: data = rdata;
         endcase
      end
   end

   assign valid = vld_q;
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
   import lsu_align_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [1:0]        size_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  offset_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [LANES-1:0]  mem_be_o,
   output logic              mem_we_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              misalign_o,
   output logic              load_valid_o,
   output logic [DATA_W-1:0] load_data_o
);
   if (DATA_W < 32 || (DATA_W % 16) != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 16 and at least 32");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed OFF_W");
   end

   acc_size_e        sz;
   logic [OFS_W-1:0] lane_ofs;
   logic             mis_raw;

   assign sz = acc_size_e'(size_i);

   lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_addr (
      .base      (base_i),
      .offset    (offset_i),
      .size      (sz),
      .word_addr (mem_addr_o),
      .lane_ofs  (lane_ofs),
      .mis       (mis_raw)
   );

   lsu_store_lane #(.DATA_W(DATA_W)) u_store (
      .active   (req_i && !mis_raw),
      .size     (sz),
      .lane_ofs (lane_ofs),
      .wdata    (wdata_i),
      .be       (mem_be_o),
      .placed   (mem_wdata_o)
   );

   lsu_load_extract #(.DATA_W(DATA_W)) u_load (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (req_i && !we_i),
      .size     (sz),
      .lane_ofs (lane_ofs),
      .mis      (mis_raw),
      .rdata    (rdata_i),
      .valid    (load_valid_o),
      .data     (load_data_o)
   );

   assign mem_we_o   = req_i && we_i && !mis_raw;
   assign misalign_o = req_i && mis_raw;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              we_i,
   input logic [1:0]        size_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [LANES-1:0]  mem_be_o,
   input logic              mem_we_o,
   input logic              misalign_o,
   input logic              load_valid_o,
   input logic [DATA_W-1:0] load_data_o
);
   a_r1_word_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_addr_o[OFS_W-1:0] == '0);

   a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && size_i == 2'd0) |-> $countones(mem_be_o) == 1);

   a_r3_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && size_i == 2'd1 && !misalign_o) |-> $countones(mem_be_o) == 2);

   a_r5_no_write_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !we_i) |-> !mem_we_o);

   a_r6_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !we_i) |=> load_valid_o);

   a_r6_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_i && !we_i) |=> (!load_valid_o && load_data_o == '0));

   a_r7_misaligned_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> (mem_be_o == '0 && !mem_we_o));

   a_r7_misaligned_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (misalign_o && !we_i) |=> load_data_o == '0);

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |-> (mem_be_o == '0 && !mem_we_o && !misalign_o));
endmodule

bind lsu_align_unit lsu_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_align_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .we_i         (we_i),
   .size_i       (size_i),
   .mem_addr_o   (mem_addr_o),
   .mem_be_o     (mem_be_o),
   .mem_we_o     (mem_we_o),
   .misalign_o   (misalign_o),
   .load_valid_o (load_valid_o),
   .load_data_o  (load_data_o)
);

// File: tb/test_lsu_align_unit.sv
`timescale 1ns/1ps
module test_lsu_align_unit;
   localparam int NV = 15;
   localparam logic [31:0] MEMW = 32'hAA1513FF;

   localparam logic          V_WE   [NV] = '{0,0,0,0,0,0,0,1,1,1,0,1,0,0,1};
   localparam logic [1:0]    V_SZ   [NV] = '{2,0,0,0,0,1,1,0,1,2,1,2,2,3,0};
   localparam logic [31:0]   V_BASE [NV] = '{32'h100,32'h200,32'h200,32'h200,32'h204,
      32'h300,32'h300,32'h400,32'h400,32'h400,32'h300,32'h400,32'h100,32'h500,32'h400};
   localparam logic [15:0]   V_OFF  [NV] = '{16'h4,16'h0,16'h1,16'h2,16'hFFFF,
      16'h0,16'h2,16'h1,16'h2,16'hFFFC,16'h1,16'h2,16'h3,16'h0,16'h3};
   localparam logic [31:0]   V_WD   [NV] = '{32'h0,32'h0,32'h0,32'h0,32'h0,32'h0,32'h0,
      32'h123456C3,32'h1234BEEF,32'hCAFEF00D,32'h0,32'h11223344,32'h0,32'h0,32'h0000005A};
   localparam logic [31:0]   E_ADDR [NV] = '{32'h104,32'h200,32'h200,32'h200,32'h200,
      32'h300,32'h300,32'h400,32'h400,32'h3FC,32'h300,32'h400,32'h100,32'h500,32'h400};
   localparam logic [3:0]    E_BE   [NV] = '{4'hF,4'h8,4'h4,4'h2,4'h1,4'hC,4'h3,
      4'h4,4'h3,4'hF,4'h0,4'h0,4'h0,4'h0,4'h1};
   localparam logic [31:0]   E_WD   [NV] = '{32'h0,32'h0,32'h0,32'h0,32'h0,32'h0,32'h0,
      32'hC3C3C3C3,32'hBEEFBEEF,32'hCAFEF00D,32'h0,32'h0,32'h0,32'h0,32'h5A5A5A5A};
   localparam logic [31:0]   E_LD   [NV] = '{32'hAA1513FF,32'hAA,32'h15,32'h13,32'hFF,
      32'hAA15,32'h13FF,32'h0,32'h0,32'h0,32'h0,32'h0,32'h0,32'h0,32'h0};
   localparam logic          E_MIS  [NV] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,1,0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0, we_i = 1'b0;
   logic [1:0]  size_i = '0;
   logic [31:0] base_i = '0, wdata_i = '0, rdata_i = '0;
   logic [15:0] offset_i = '0;
   logic [31:0] mem_addr_o, mem_wdata_o, load_data_o;
   logic [3:0]  mem_be_o;
   logic        mem_we_o, misalign_o, load_valid_o;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   lsu_align_unit i_lsu_align_unit (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .size_i(size_i),
      .base_i(base_i), .offset_i(offset_i), .wdata_i(wdata_i), .rdata_i(rdata_i),
      .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_we_o(mem_we_o),
      .mem_wdata_o(mem_wdata_o), .misalign_o(misalign_o),
      .load_valid_o(load_valid_o), .load_data_o(load_data_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9 load_valid in reset", 32'(load_valid_o), 0);
      chk("R8 be in reset", 32'(mem_be_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 load_valid after reset", 32'(load_valid_o), 0);

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         req_i = 1'b1; we_i = V_WE[v]; size_i = V_SZ[v];
         base_i = V_BASE[v]; offset_i = V_OFF[v]; wdata_i = V_WD[v];
         #1;
         chk($sformatf("R1 addr v%0d", v), mem_addr_o, E_ADDR[v]);
         chk($sformatf("R2 R3 be v%0d", v), 32'(mem_be_o), 32'(E_BE[v]));
         chk($sformatf("R7 misalign v%0d", v), 32'(misalign_o), 32'(E_MIS[v]));
         chk($sformatf("R5 we v%0d", v), 32'(mem_we_o), 32'(V_WE[v] && !E_MIS[v]));
         if (V_WE[v] && !E_MIS[v])
            chk($sformatf("R4 wdata v%0d", v), mem_wdata_o, E_WD[v]);
         @(negedge clk);
         req_i = 1'b0; rdata_i = MEMW;
         #1;
         chk($sformatf("R6 valid v%0d", v), 32'(load_valid_o), 32'(!V_WE[v]));
         chk($sformatf("R6 R7 load v%0d", v), load_data_o, E_LD[v]);
         chk($sformatf("R8 idle be v%0d", v), 32'(mem_be_o), 0);
      end

      // R1: address wraps past the top of the space
      @(negedge clk);
      req_i = 1'b1; we_i = 1'b0; size_i = 2'd2; base_i = 32'hFFFFFFFE; offset_i = 16'h0006;
      #1;
      chk("R1 wrap addr", mem_addr_o, 32'h4);
      @(negedge clk);
      req_i = 1'b0; rdata_i = 32'h01020304;
      #1;
      chk("R6 word load passthrough", load_data_o, 32'h01020304);
      // R6: no load in the previous cycle -> result idle
      @(negedge clk);
      #1;
      chk("R6 valid drops", 32'(load_valid_o), 0);
      chk("R6 data zero when idle", load_data_o, 0);
      chk("R8 misalign idle", 32'(misalign_o), 0);

      // R9: reset in the middle of a pending load
      @(negedge clk);
      req_i = 1'b1; we_i = 1'b0; size_i = 2'd0; base_i = 32'h0; offset_i = 16'h0;
      @(negedge clk);
      req_i = 1'b0; rst_n = 1'b0;
      #1;
      chk("R9 reset clears pending load", 32'(load_valid_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R9 stays idle after reset", 32'(load_valid_o), 0);
      report();
   end
endmodule